// File: doc/BRIEF.md
# Sleep and Power-Save Mode Sequencer

This block chooses the bus clock source and rate of an embedded controller, and it runs the ordered steps for entering and leaving a low-power sleep state. It supports three operating modes. In full-rate mode the bus runs at twice the fast oscillator. In the reduced-rate mode the bus runs at half the fast oscillator, which is one quarter of full rate. In sleep the bus runs from a 32 kHz slow oscillator. The block does not generate clocks. It drives enable and divide codes to a clock generator elsewhere. A `slowTick` strobe, one clock wide and issued once per slow-oscillator period, is the time base for every wait in the block.

Sleep is armed by a sleep-enable bit and a 4-bit wait value. When the wait runs out, the block performs these steps in order: it notifies the host, masks every interrupt, hands the clock over to the slow oscillator through a gap cycle, and stops the external fast oscillator if its control pin has that role. It then halts. Only the dedicated wake pin can end sleep, and it must be held low for two consecutive slow samples. Recovery runs the same steps in reverse and includes a stabilisation wait. At the end the block returns to full rate, or to reduced rate if that mode is still enabled.

Top module: `pmc_top`

## Requirements
- R1: After reset the block is in full-rate mode: `modeStatus`=0, `busDiv`=0, `fastClkEn`=1, `slowClkEn`=0, `oscCtlN`=1, both notice pulses low, `halted`=0, and `irqOut` equals `irqIn`.
- R2: In the running state, `pwrSaveEn`=1 gives `busDiv`=1 (fast oscillator divided by two), and `pwrSaveEn`=0 gives `busDiv`=0 (fast oscillator doubled). `fastEthOk` is 1 only when `busDiv`=0.
- R3: While `sleepEn` is held at 1 in the running state, the wait counter is loaded with `sleepWait`=W. Entry begins on the (W+1)-th `slowTick`. W=0 therefore enters on the first tick.
- R4: Deasserting `sleepEn` before expiry cancels the wait and reloads the counter. A later arm needs a full W+1 ticks again.
- R5: Entry takes exactly one cycle per step, in this order: a one-cycle `sleepNotice` pulse, then interrupt masking, then a gap with both clock enables low (`busDiv`=3), then the slow clock on (`busDiv`=2), then oscillator shutdown, then `halted`=1.
- R6: `oscCtlN` is driven low from the shutdown step until recovery begins, but only when `oscCtlSel`=1. `oscCtlOe` follows `oscCtlSel`. With `oscCtlSel`=0, `oscCtlN` stays 1.
- R7: `irqOut` is forced to 0 from the masking step until the wake notice. Interrupt inputs never end sleep. At all other times `irqOut` equals `irqIn`.
- R8: `wakePinN` is sampled on `slowTick` through two synchroniser flops. Recovery starts on the fourth tick of a low level that lasted at least two ticks. A low level that lasts one tick is ignored.
- R9: Recovery releases `oscCtlN` with the slow clock still on. It then waits `STAB_TICKS` slow ticks, holds a gap cycle, switches to the fast clock, and pulses `wakeNotice` for one cycle.
- R10: After recovery the block runs at `busDiv`=1 if `pwrSaveEn`=1, and at `busDiv`=0 otherwise.
- R11: `modeStatus` reports 0 for full rate, 1 for reduced rate, 2 for entering, 3 for asleep and 4 for recovering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| slowTick | input | 1 | One-cycle strobe per slow-oscillator period |
| pwrSaveEn | input | 1 | Reduced-rate mode enable |
| sleepEn | input | 1 | Sleep arm |
| sleepWait | input | WAIT_W | Sleep wait in slow ticks, minus one |
| wakePinN | input | 1 | Dedicated wake pin, active low |
| oscCtlSel | input | 1 | Pin role: 1 = fast oscillator control, 0 = general I/O |
| irqIn | input | IRQ_W | Interrupt requests |
| irqOut | output | IRQ_W | Gated interrupt requests |
| fastClkEn | output | 1 | Bus clock taken from fast oscillator |
| slowClkEn | output | 1 | Bus clock taken from slow oscillator |
| busDiv | output | 2 | 0 fast x2, 1 fast /2, 2 slow, 3 gated |
| oscCtlN | output | 1 | Fast oscillator run control, active low |
| oscCtlOe | output | 1 | Drive enable for the oscillator control pin |
| fastEthOk | output | 1 | Bus rate supports 100 Mbit Ethernet |
| sleepNotice | output | 1 | One-cycle pulse at sleep entry |
| wakeNotice | output | 1 | One-cycle pulse at end of recovery |
| halted | output | 1 | Asleep |
| modeStatus | output | 3 | Mode code, see R11 |

## Verification
The bench targets the off-by-one boundaries. With W=0, entry must come on the first tick; a design that counts one tick too few or too many moves the `sleepNotice` pulse. It also targets the stabilisation count, where an early exit would switch to an unsettled oscillator. A one-tick wake glitch must not wake the block; a design without the second-sample check would wake on noise. The bench checks every entry and recovery step on its own cycle, so a missing gap cycle, out-of-order masking, or an oscillator shutdown with the pin in its general I/O role each appears as a wrong value at that step. It also checks the abort reload and the return to reduced rate after wake.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [3:0] {
    ST_RUN      = 4'd0,
    ST_ENT_NOTE = 4'd1,
    ST_ENT_MASK = 4'd2,
    ST_ENT_GAP  = 4'd3,
    ST_ENT_SLOW = 4'd4,
    ST_ENT_OSC  = 4'd5,
    ST_SLEEP    = 4'd6,
    ST_REC_OSC  = 4'd7,
    ST_REC_STAB = 4'd8,
    ST_REC_GAP  = 4'd9,
    ST_REC_FAST = 4'd10,
    ST_REC_NOTE = 4'd11
  } pmcState_e;

  localparam logic [1:0] DIV_FAST_X2   = 2'd0;
  localparam logic [1:0] DIV_FAST_HALF = 2'd1;
  localparam logic [1:0] DIV_SLOW      = 2'd2;
  localparam logic [1:0] DIV_GATED     = 2'd3;

  localparam logic [2:0] MODE_NORMAL = 3'd0;
  localparam logic [2:0] MODE_PSAVE  = 3'd1;
  localparam logic [2:0] MODE_ENTER  = 3'd2;
  localparam logic [2:0] MODE_SLEEP  = 3'd3;
  localparam logic [2:0] MODE_RECOV  = 3'd4;

  typedef struct packed {
    logic loadWait;
    logic runWait;
    logic loadStab;
    logic runStab;
  } pmcStrobe_t;

endpackage

// File: rtl/pmc_datapath.sv
module pmc_datapath
  import pmc_pkg::*;
#(
  parameter int WAIT_W     = 4,
  parameter int STAB_TICKS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slowTick,
  input  logic [WAIT_W-1:0] sleepWait,
  input  logic              wakePinN,
  input  pmcStrobe_t        strobe,
  output logic              waitDone,
  output logic              stabDone,
  output logic              wakeSeen
);

  localparam int STB_W = $clog2(STAB_TICKS + 1);
  localparam logic [WAIT_W-1:0] WAIT_ONE = 1;
  localparam logic [STB_W-1:0]  STB_ONE  = 1;
  localparam logic [STB_W-1:0]  STB_LOAD = STB_W'(STAB_TICKS - 1);

  logic [WAIT_W-1:0] waitCnt;
  logic [STB_W-1:0]  stabCnt;
  logic              syncQ1, syncQ2, prevLow;

  // sleep wait: counts slow ticks down to zero, expiry on the tick seen at zero
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitCnt <= '0;
    end else if (strobe.loadWait) begin
      waitCnt <= sleepWait;
    end else if (strobe.runWait && slowTick && waitCnt != '0) begin
      waitCnt <= waitCnt - WAIT_ONE;
    end
  end

  assign waitDone = strobe.runWait && slowTick && (waitCnt == '0);

  // oscillator settle window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stabCnt <= STB_LOAD;
    end else if (strobe.loadStab) begin
      stabCnt <= STB_LOAD;
    end else if (strobe.runStab && slowTick && stabCnt != '0) begin
      stabCnt <= stabCnt - STB_ONE;
    end
  end

  assign stabDone = strobe.runStab && slowTick && (stabCnt == '0);

  // wake pin synchroniser plus second-sample qualifier, slow-tick sampled
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ1  <= 1'b1;
      syncQ2  <= 1'b1;
      prevLow <= 1'b0;
    end else if (slowTick) begin
      syncQ1  <= wakePinN;
      syncQ2  <= syncQ1;
      prevLow <= !syncQ2;
    end
  end

  assign wakeSeen = slowTick && !syncQ2 && prevLow;

  assert_wait_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.runWait && !slowTick) |=> $stable(waitCnt));

  assert_wait_reload_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadWait |=> (waitCnt == $past(sleepWait)));

  assert_stab_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.runStab && !slowTick) |=> $stable(stabCnt));

endmodule

// File: rtl/pmc_ctrl.sv
module pmc_ctrl
  import pmc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwrSaveEn,
  input  logic       sleepEn,
  input  logic       oscCtlSel,
  input  logic       waitDone,
  input  logic       stabDone,
  input  logic       wakeSeen,
  output pmcStrobe_t strobe,
  output logic       irqMask,
  output logic       fastClkEn,
  output logic       slowClkEn,
  output logic [1:0] busDiv,
  output logic       oscCtlN,
  output logic       sleepNotice,
  output logic       wakeNotice,
  output logic       halted,
  output logic [2:0] modeStatus
);

  pmcState_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RUN;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    unique case (state)
      ST_RUN:      if (waitDone) nextState = ST_ENT_NOTE;
      ST_ENT_NOTE: nextState = ST_ENT_MASK;
      ST_ENT_MASK: nextState = ST_ENT_GAP;
      ST_ENT_GAP:  nextState = ST_ENT_SLOW;
      ST_ENT_SLOW: nextState = ST_ENT_OSC;
      ST_ENT_OSC:  nextState = ST_SLEEP;
      ST_SLEEP:    if (wakeSeen) nextState = ST_REC_OSC;
      ST_REC_OSC:  nextState = ST_REC_STAB;
      ST_REC_STAB: if (stabDone) nextState = ST_REC_GAP;
      ST_REC_GAP:  nextState = ST_REC_FAST;
      ST_REC_FAST: nextState = ST_REC_NOTE;
      ST_REC_NOTE: nextState = ST_RUN;
      default:     nextState = ST_RUN;
    endcase
  end

  logic inRun;
  assign inRun = (state == ST_RUN);

  always_comb begin
    strobe.runWait  = inRun && sleepEn;
    strobe.loadWait = !(inRun && sleepEn);
    strobe.runStab  = (state == ST_REC_STAB);
    strobe.loadStab = (state != ST_REC_STAB);
  end

  always_comb begin
    fastClkEn = 1'b0;
    slowClkEn = 1'b0;
    unique case (state)
      ST_RUN, ST_ENT_NOTE, ST_ENT_MASK, ST_REC_FAST, ST_REC_NOTE: fastClkEn = 1'b1;
      ST_ENT_SLOW, ST_ENT_OSC, ST_SLEEP, ST_REC_OSC, ST_REC_STAB: slowClkEn = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    if (fastClkEn)      busDiv = pwrSaveEn ? DIV_FAST_HALF : DIV_FAST_X2;
    else if (slowClkEn) busDiv = DIV_SLOW;
    else                busDiv = DIV_GATED;
  end

  always_comb begin
    unique case (state)
      ST_RUN:                                      modeStatus = pwrSaveEn ? MODE_PSAVE : MODE_NORMAL;
      ST_ENT_NOTE, ST_ENT_MASK, ST_ENT_GAP,
      ST_ENT_SLOW, ST_ENT_OSC:                     modeStatus = MODE_ENTER;
      ST_SLEEP:                                    modeStatus = MODE_SLEEP;
      default:                                     modeStatus = MODE_RECOV;
    endcase
  end

  assign irqMask     = !(inRun || state == ST_ENT_NOTE || state == ST_REC_NOTE);
  assign oscCtlN     = !(oscCtlSel && (state == ST_ENT_OSC || state == ST_SLEEP));
  assign sleepNotice = (state == ST_ENT_NOTE);
  assign wakeNotice  = (state == ST_REC_NOTE);
  assign halted      = (state == ST_SLEEP);

  assert_sleep_notice_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    sleepNotice |=> !sleepNotice);

  assert_slow_after_gap_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(slowClkEn) |-> !$past(fastClkEn));

  assert_fast_after_gap_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fastClkEn) |-> !$past(slowClkEn));

  assert_wake_by_pin_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(halted) |-> $past(wakeSeen));

  assert_wake_notice_fast_R9: assert property (@(posedge clk) disable iff (!rstN)
    wakeNotice |-> $past(fastClkEn));

  assert_mask_in_sleep_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(halted) |-> $past(irqMask, 4));

endmodule

// File: rtl/pmc_top.sv
module pmc_top
  import pmc_pkg::*;
#(
  parameter int WAIT_W     = 4,
  parameter int STAB_TICKS = 4,
  parameter int IRQ_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slowTick,
  input  logic              pwrSaveEn,
  input  logic              sleepEn,
  input  logic [WAIT_W-1:0] sleepWait,
  input  logic              wakePinN,
  input  logic              oscCtlSel,
  input  logic [IRQ_W-1:0]  irqIn,
  output logic [IRQ_W-1:0]  irqOut,
  output logic              fastClkEn,
  output logic              slowClkEn,
  output logic [1:0]        busDiv,
  output logic              oscCtlN,
  output logic              oscCtlOe,
  output logic              fastEthOk,
  output logic              sleepNotice,
  output logic              wakeNotice,
  output logic              halted,
  output logic [2:0]        modeStatus
);

  pmcStrobe_t strobe;
  logic waitDone, stabDone, wakeSeen, irqMask;

  pmc_datapath #(.WAIT_W(WAIT_W), .STAB_TICKS(STAB_TICKS)) u_datapath (
    .clk(clk), .rstN(rstN), .slowTick(slowTick), .sleepWait(sleepWait),
    .wakePinN(wakePinN), .strobe(strobe), .waitDone(waitDone),
    .stabDone(stabDone), .wakeSeen(wakeSeen)
  );

  pmc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .pwrSaveEn(pwrSaveEn), .sleepEn(sleepEn),
    .oscCtlSel(oscCtlSel), .waitDone(waitDone), .stabDone(stabDone),
    .wakeSeen(wakeSeen), .strobe(strobe), .irqMask(irqMask),
    .fastClkEn(fastClkEn), .slowClkEn(slowClkEn), .busDiv(busDiv),
    .oscCtlN(oscCtlN), .sleepNotice(sleepNotice), .wakeNotice(wakeNotice),
    .halted(halted), .modeStatus(modeStatus)
  );

  assign irqOut    = irqMask ? '0 : irqIn;
  assign oscCtlOe  = oscCtlSel;
  assign fastEthOk = (busDiv == DIV_FAST_X2);

  assert_eth_only_full_rate_R2: assert property (@(posedge clk) disable iff (!rstN)
    fastEthOk |-> (fastClkEn && !pwrSaveEn));

  assert_osc_role_R6: assert property (@(posedge clk) disable iff (!rstN)
    !oscCtlN |-> (oscCtlOe && slowClkEn));

endmodule

// File: tb/pmc_top_bench.sv
module pmc_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int STAB = 4;

  logic clk = 1'b0, rstN = 1'b0, slowTick = 1'b0, pwrSaveEn = 1'b0, sleepEn = 1'b0;
  logic [3:0] sleepWait = '0;
  logic wakePinN = 1'b1, oscCtlSel = 1'b0;
  logic [7:0] irqIn = 8'hA5;
  logic [7:0] irqOut;
  logic fastClkEn, slowClkEn, oscCtlN, oscCtlOe, fastEthOk, sleepNotice, wakeNotice, halted;
  logic [1:0] busDiv;
  logic [2:0] modeStatus;
  int nChecks = 0, nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmc_top #(.WAIT_W(4), .STAB_TICKS(STAB), .IRQ_W(8)) u_pmc_top (
    .clk(clk), .rstN(rstN), .slowTick(slowTick), .pwrSaveEn(pwrSaveEn), .sleepEn(sleepEn),
    .sleepWait(sleepWait), .wakePinN(wakePinN), .oscCtlSel(oscCtlSel), .irqIn(irqIn),
    .irqOut(irqOut), .fastClkEn(fastClkEn), .slowClkEn(slowClkEn), .busDiv(busDiv),
    .oscCtlN(oscCtlN), .oscCtlOe(oscCtlOe), .fastEthOk(fastEthOk), .sleepNotice(sleepNotice),
    .wakeNotice(wakeNotice), .halted(halted), .modeStatus(modeStatus)
  );

  function automatic int expRunDiv(input logic ps); return ps ? 1 : 0; endfunction
  function automatic int expOscN(input logic sel, input logic off); return (sel && off) ? 0 : 1; endfunction

  task automatic chk(input int act, input int exp, input string what);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic cyc(); @(posedge clk); @(negedge clk); endtask
  task automatic tick(); slowTick = 1'b1; cyc(); slowTick = 1'b0; endtask

  task automatic enterSleep(input int w, input logic sel);
    sleepEn = 1'b0; sleepWait = 4'(w); oscCtlSel = sel; cyc();
    sleepEn = 1'b1;
    for (int i = 0; i < w; i++) begin
      tick(); chk(sleepNotice, 0, "R3 no notice before expiry");
    end
    tick();
    chk(sleepNotice, 1, "R3 notice on tick W+1");
    chk(modeStatus, 2, "R11 entering code");
    chk(irqOut, irqIn, "R7 unmasked at notice");
    cyc();
    chk(sleepNotice, 0, "R5 notice single cycle");
    chk(irqOut, 0, "R7 masked at step two");
    chk(fastClkEn, 1, "R5 still fast at mask step");
    cyc();
    chk({fastClkEn, slowClkEn}, 0, "R5 entry gap");
    chk(busDiv, 3, "R5 gated code");
    cyc();
    chk(slowClkEn, 1, "R5 slow clock on");
    chk(busDiv, 2, "R5 slow code");
    chk(oscCtlN, 1, "R6 osc still running");
    cyc();
    chk(oscCtlN, expOscN(sel, 1'b1), "R6 osc shutdown step");
    chk(oscCtlOe, sel, "R6 pin role");
    chk(halted, 0, "R5 not yet halted");
    cyc();
    chk(halted, 1, "R5 halted");
    chk(modeStatus, 3, "R11 sleep code");
    chk(oscCtlN, expOscN(sel, 1'b1), "R6 osc held off");
  endtask

  task automatic wakeUp(input logic ps);
    irqIn = 8'hFF; tick(); tick();
    chk(halted, 1, "R7 interrupts do not wake");
    chk(irqOut, 0, "R7 masked in sleep");
    wakePinN = 1'b0;
    for (int i = 0; i < 3; i++) begin
      tick(); chk(halted, 1, "R8 still asleep during sync");
    end
    tick();
    chk(halted, 0, "R8 wake on fourth tick");
    chk(modeStatus, 4, "R11 recovery code");
    chk(oscCtlN, 1, "R9 osc released first");
    chk(slowClkEn, 1, "R9 slow during release");
    wakePinN = 1'b1;
    cyc();
    for (int i = 0; i < STAB - 1; i++) begin
      tick(); chk(slowClkEn, 1, "R9 stabilisation wait");
    end
    tick();
    chk({fastClkEn, slowClkEn}, 0, "R9 recovery gap");
    cyc();
    chk(fastClkEn, 1, "R9 fast clock back");
    chk(busDiv, expRunDiv(ps), "R10 rate on fast switch");
    chk(wakeNotice, 0, "R9 notice after switch");
    chk(irqOut, 0, "R7 masked until notice");
    cyc();
    chk(wakeNotice, 1, "R9 wake notice");
    chk(irqOut, irqIn, "R7 unmasked at notice");
    cyc();
    chk(wakeNotice, 0, "R9 notice single cycle");
    chk(modeStatus, ps ? 1 : 0, "R10 mode after wake");
    chk(busDiv, expRunDiv(ps), "R10 rate after wake");
    sleepEn = 1'b0;
    tick(); tick(); tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) cyc();
    rstN = 1'b1; cyc();
    // R1 reset state
    chk(modeStatus, 0, "R1 status");
    chk(busDiv, 0, "R1 div");
    chk({fastClkEn, slowClkEn}, 2, "R1 clock enables");
    chk(oscCtlN, 1, "R1 osc ctl");
    chk({sleepNotice, wakeNotice, halted}, 0, "R1 notices");
    chk(irqOut, irqIn, "R1 irq pass");
    chk(fastEthOk, 1, "R2 eth ok full rate");
    // R2 reduced rate
    pwrSaveEn = 1'b1; cyc();
    chk(busDiv, 1, "R2 half rate");
    chk(fastEthOk, 0, "R2 eth off in reduced rate");
    chk(modeStatus, 1, "R11 psave code");
    pwrSaveEn = 1'b0; cyc();
    chk(busDiv, 0, "R2 back to full rate");
    // R4 abort reload
    sleepWait = 4'd5; cyc(); sleepEn = 1'b1;
    tick(); tick(); tick();
    sleepEn = 1'b0; cyc(); sleepEn = 1'b1;
    for (int i = 0; i < 5; i++) begin
      tick(); chk(sleepNotice, 0, "R4 reload after abort");
    end
    tick(); chk(sleepNotice, 1, "R4 full wait after rearm");
    repeat (5) cyc();
    chk(halted, 1, "R5 halted after abort run");
    wakeUp(1'b0);
    // R3 W=0 boundary, osc pin in I/O role
    enterSleep(0, 1'b0);
    // R8 one-tick glitch ignored
    wakePinN = 1'b0; tick(); wakePinN = 1'b1;
    for (int i = 0; i < 4; i++) begin
      tick(); chk(halted, 1, "R8 glitch ignored");
    end
    wakeUp(1'b0);
    // R3 W=15 boundary, osc control role, return to reduced rate
    pwrSaveEn = 1'b1;
    enterSleep(15, 1'b1);
    wakeUp(1'b1);
    // random mix
    for (int k = 0; k < 8; k++) begin
      int w;
      logic ps, sel;
      w = int'($urandom % 16); ps = 1'($urandom); sel = 1'($urandom);
      irqIn = 8'($urandom); pwrSaveEn = ps;
      cyc();
      chk(irqOut, irqIn, "R7 random pass-through");
      chk(busDiv, expRunDiv(ps), "R2 random rate");
      enterSleep(w, sel);
      wakeUp(ps);
    end
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule